// File: doc/BRIEF.md
# Output Impedance Calibration Controller

This block holds the digital side of an output-driver impedance loop. An external analog comparator reports whether the driver strength should go up, go down, or stay where it is. Once every 32 clock cycles the controller samples that decision and computes a new 6-bit drive code one step away from the code currently in use. The drivers must never change strength while they are driving a read, so the new code is held as pending until a cycle in which the outputs are in high impedance. Such a cycle is a write, a deselect, or any cycle with output enable deasserted.

The controller also counts cycles that are not read operations after reset. It raises a ready flag once enough of them have passed that the loop is guaranteed to have converged. A strap input selects the fixed minimum-impedance setting, which bypasses calibration entirely. The comparator and the output drivers are outside the block.

Top module: `zcal_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), drv_code is 32 (mid-scale) and cal_ready is 0.
- R2: The comparator is sampled only at the 32nd rising edge after reset release and at every 32nd edge after that. Comparator values at all other edges have no effect.
- R3: At a sampling edge, cmp_up=1 with cmp_dn=0 makes the pending code equal to the applied code plus one. cmp_dn=1 with cmp_up=0 makes it the applied code minus one. Any other combination discards any pending code and requests no change.
- R4: The code saturates: a step up from 63 stays 63, a step down from 0 stays 0, and the code never wraps.
- R5: A cycle is high-Z when op_sel=0, op_rd=0 or oe_n=1. The code seen on drv_code (strap_min low) changes only at an edge whose sampled cycle is high-Z.
- R6: A pending code is applied at the first later edge that samples a high-Z cycle and is not itself a sampling edge. A newer evaluation replaces a pending code that has not yet been applied. Each evaluation is computed from the code currently applied, so drv_code moves by at most one per evaluation.
- R7: While strap_min=1, drv_code is 63 (minimum impedance) in the same cycle. Evaluations are ignored and any pending code is dropped. The calibrated code is held unchanged and reappears on drv_code when strap_min returns to 0.
- R8: The ready counter advances at each edge whose cycle is not a read (a read is op_sel=1 and op_rd=1). cal_ready rises once 1024 such edges have been counted and then stays 1 until reset.
- R9: A read cycle with oe_n=1 counts as high-Z for applying a code (R5) but is not counted as a non-read cycle (R8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 1 | Device selected this cycle |
| op_rd | input | 1 | Selected cycle is a read (0 = write) |
| oe_n | input | 1 | Output enable, active low |
| cmp_up | input | 1 | Comparator requests a stronger driver |
| cmp_dn | input | 1 | Comparator requests a weaker driver |
| strap_min | input | 1 | Force minimum-impedance code, bypass calibration |
| drv_code | output | 6 | Impedance code presented to the drivers |
| cal_ready | output | 1 | Calibration guaranteed settled |

## Verification
The bench holds the comparator at "up" for long enough to drive the code into 63, then at "down" until it reaches 0. A design that wraps or overshoots at either end would show 0 after 63, or 63 after 0. A long run of driving reads across several evaluation edges checks that the pending step is held back and that only the latest one lands. A design that applies steps during reads, or that stacks several steps, would move the code while outputs drive, or jump by more than one. Reads with output enable deasserted are mixed in. They must release pending codes but must not advance the ready counter, so a design that confuses the two conditions would raise cal_ready at the wrong cycle. A strap window with the comparator active checks that the forced code appears at once. It also checks that the held code returns unchanged afterwards.

// File: rtl/zcal_pkg.sv
// Shared types and helpers for the impedance calibration controller.
// Assumes a single clock domain; nothing here holds state.
package zcal_pkg;

    // Direction decided by one evaluation of the comparator.
    typedef enum logic [1:0] {
        ZDIR_HOLD = 2'd0,
        ZDIR_UP   = 2'd1,
        ZDIR_DOWN = 2'd2
    } zdir_e;

    // Decode the two comparator bits; contradictory or idle means hold.
    function automatic zdir_e decode_dir(input logic up, input logic dn);
        if (up && !dn)      return ZDIR_UP;
        else if (dn && !up) return ZDIR_DOWN;
        else                return ZDIR_HOLD;
    endfunction

endpackage

// File: rtl/zcal_eval_timer.sv
// Free-running evaluation timer: emits a one-cycle tick every PERIOD
// clocks, the first on the PERIOD-th edge after reset release.
// Assumes PERIOD >= 2.
module zcal_eval_timer #(
    parameter int PERIOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic eval_tick
);
    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count edges modulo PERIOD.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign eval_tick = (cnt_q == LAST);
endmodule

// File: rtl/zcal_code_reg.sv
// Holds the applied impedance code and one pending step. On an
// evaluation tick the pending code is reloaded one saturating step from
// the applied code; otherwise a pending code is applied on a high-Z cycle.
// Assumes bypass freezes the loop and discards anything pending.
module zcal_code_reg
    import zcal_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int RESET_CODE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_tick,
    input  zdir_e             dir,
    input  logic              hiz,
    input  logic              bypass,
    output logic [CODE_W-1:0] code_q
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN = '0;
    localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

    logic              pend_v_q;
    logic [CODE_W-1:0] pend_q;
    logic [CODE_W-1:0] step_code;

    // Saturating one-step target computed from the applied code.
    always_comb begin
        step_code = code_q;
        if (dir == ZDIR_UP && code_q != CODE_MAX)   step_code = code_q + 1'b1;
        if (dir == ZDIR_DOWN && code_q != CODE_MIN) step_code = code_q - 1'b1;
    end

    // Pending step register: load on evaluation, clear on apply or bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v_q <= 1'b0;
            pend_q   <= CODE_RST;
        end else if (bypass) begin
            pend_v_q <= 1'b0;
        end else if (eval_tick) begin
            pend_v_q <= (dir != ZDIR_HOLD);
            pend_q   <= step_code;
        end else if (hiz && pend_v_q) begin
            pend_v_q <= 1'b0;
        end
    end

    // Applied code: takes the pending value only in a high-Z cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= CODE_RST;
        else if (!bypass && !eval_tick && hiz && pend_v_q)
            code_q <= pend_q;
    end
endmodule

// File: rtl/zcal_settle_cnt.sv
// Counts non-read cycles after reset and raises ready at LIMIT, holding
// there. Assumes LIMIT >= 1.
module zcal_settle_cnt #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nonread,
    output logic ready
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Saturating count of qualifying cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (nonread && cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
    end

    assign ready = (cnt_q == TERM);
endmodule

// File: rtl/zcal_ctrl.sv
// Top of the impedance calibration controller. Classifies each cycle as
// read / high-Z, runs the periodic evaluation, gates code updates to
// high-Z cycles and tracks settle time. Assumes op_* and oe_n describe
// the current cycle and are synchronous to clk.
module zcal_ctrl
    import zcal_pkg::*;
#(
    parameter int CODE_W        = 6,
    parameter int EVAL_PERIOD   = 32,
    parameter int SETTLE_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_sel,
    input  logic              op_rd,
    input  logic              oe_n,
    input  logic              cmp_up,
    input  logic              cmp_dn,
    input  logic              strap_min,
    output logic [CODE_W-1:0] drv_code,
    output logic              cal_ready
);
    localparam int MID_CODE = 2 ** (CODE_W - 1);

    logic              is_read;
    logic              hiz;
    logic              eval_tick;
    zdir_e             dir;
    logic [CODE_W-1:0] cal_code;

    assign is_read = op_sel && op_rd;
    assign hiz     = !is_read || oe_n;
    assign dir     = decode_dir(cmp_up, cmp_dn);

    zcal_eval_timer #(.PERIOD(EVAL_PERIOD)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_tick (eval_tick)
    );

    zcal_code_reg #(.CODE_W(CODE_W), .RESET_CODE(MID_CODE)) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_tick (eval_tick),
        .dir       (dir),
        .hiz       (hiz),
        .bypass    (strap_min),
        .code_q    (cal_code)
    );

    zcal_settle_cnt #(.LIMIT(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .nonread (!is_read),
        .ready   (cal_ready)
    );

    // Strap forces the strongest (minimum-impedance) setting.
    assign drv_code = strap_min ? {CODE_W{1'b1}} : cal_code;
endmodule

// File: rtl/zcal_ctrl_chk.sv
// Port-level properties for zcal_ctrl, bound into every instance.
module zcal_ctrl_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_sel,
    input logic              op_rd,
    input logic              oe_n,
    input logic              strap_min,
    input logic [CODE_W-1:0] drv_code,
    input logic              cal_ready
);
    localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] MIDC = CODE_W'(2 ** (CODE_W - 1));

    logic seen_q;
    logic started_q;
    logic hiz_c;

    assign hiz_c = !(op_sel && op_rd) || oe_n;

    // Marks that at least one edge out of reset has occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // Marks that any edge at all has occurred.
    always_ff @(posedge clk) started_q <= 1'b1;

    // R1: reset state visible on the edge after reset.
    assert_reset_state_R1: assert property (@(posedge clk)
        (started_q && rst_n && !$past(rst_n)) |-> (drv_code == MIDC && !cal_ready));

    // R4 and R6: at most one step per edge, no wrap.
    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !strap_min && !$past(strap_min)) |->
        (drv_code == $past(drv_code) || drv_code == $past(drv_code) + 1'b1 ||
         drv_code == $past(drv_code) - 1'b1) &&
        !($past(drv_code) == MAXC && drv_code == '0) &&
        !($past(drv_code) == '0 && drv_code == MAXC));

    // R5: a change of the code needs a high-Z cycle.
    assert_hiz_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !strap_min && !$past(strap_min) && drv_code != $past(drv_code))
        |-> $past(hiz_c));

    // R7: strap forces the minimum-impedance code.
    assert_strap_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strap_min |-> drv_code == MAXC);

    // R8: ready never falls while out of reset.
    assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(cal_ready)) |-> cal_ready);
endmodule

bind zcal_ctrl zcal_ctrl_chk #(.CODE_W(CODE_W)) u_zcal_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .op_rd     (op_rd),
    .oe_n      (oe_n),
    .strap_min (strap_min),
    .drv_code  (drv_code),
    .cal_ready (cal_ready)
);

// File: tb/zcal_ctrl_tb_top.sv
`timescale 1ns/1ps
module zcal_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_sel = 1'b0, op_rd = 1'b0, oe_n = 1'b0;
    logic       cmp_up = 1'b0, cmp_dn = 1'b0, strap_min = 1'b0;
    logic [5:0] drv_code;
    logic       cal_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Behavioural reference state.
    int m_code = 32, m_pend = 32, m_t = 0, m_cnt = 0;
    bit m_pv = 0;

    always #4 clk = ~clk;

    zcal_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .op_rd(op_rd), .oe_n(oe_n),
        .cmp_up(cmp_up), .cmp_dn(cmp_dn), .strap_min(strap_min),
        .drv_code(drv_code), .cal_ready(cal_ready)
    );

    // Reference model, advanced with the inputs seen at each rising edge.
    always @(posedge clk) begin
        bit rd, hz, ev;
        if (!rst_n) begin
            m_code = 32; m_pend = 32; m_pv = 0; m_t = 0; m_cnt = 0;
        end else begin
            rd = op_sel && op_rd;
            hz = !rd || oe_n;
            ev = (m_t == 31);
            m_t = (m_t + 1) % 32;
            if (strap_min) m_pv = 0;
            else if (ev) begin
                if (cmp_up && !cmp_dn) begin
                    m_pend = (m_code < 63) ? m_code + 1 : 63; m_pv = 1;
                end else if (cmp_dn && !cmp_up) begin
                    m_pend = (m_code > 0) ? m_code - 1 : 0; m_pv = 1;
                end else m_pv = 0;
            end else if (hz && m_pv) begin
                m_code = m_pend; m_pv = 0;
            end
            if (!rd && m_cnt < 1024) m_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs against the model, away from the active edge.
    task automatic cmp_model();
        chk("R2 R3 R5 R6 R7 drv_code", int'(drv_code), strap_min ? 63 : m_code);
        chk("R8 R9 cal_ready", int'(cal_ready), int'(m_cnt == 1024));
    endtask

    // One cycle: check, then drive the next cycle's inputs.
    task automatic cyc(input int kind, input bit up, input bit dn);
        @(negedge clk);
        cmp_model();
        case (kind)
            0: begin op_sel = 0; op_rd = 0; oe_n = 0; end // deselect
            1: begin op_sel = 1; op_rd = 1; oe_n = 0; end // driving read
            2: begin op_sel = 1; op_rd = 0; oe_n = 0; end // write
            default: begin op_sel = 1; op_rd = 1; oe_n = 1; end // read, oe off
        endcase
        cmp_up = up; cmp_dn = dn;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset code", int'(drv_code), 32);
        chk("R1 reset ready", int'(cal_ready), 0);
        // Ramp up with mixed traffic until saturation at the top.
        for (int i = 0; i < 1400; i++) cyc($urandom_range(0, 3), 1, 0);
        cyc(0, 1, 0);
        chk("R4 top saturation", int'(drv_code), 63);
        // Ramp down to the bottom.
        for (int i = 0; i < 2600; i++) cyc($urandom_range(0, 3), 0, 1);
        cyc(0, 0, 1);
        chk("R4 bottom saturation", int'(drv_code), 0);
        // Driving reads across several evaluations: code must hold.
        for (int i = 0; i < 130; i++) cyc(1, 1, 0);
        cyc(1, 1, 0);
        chk("R6 held while driving", int'(drv_code), 0);
        for (int i = 0; i < 10; i++) cyc(2, 1, 0);
        chk("R6 single step after release", int'(drv_code), 1);
        // Reads with oe off: apply steps, do not count toward ready.
        for (int i = 0; i < 200; i++) cyc(3, 1, 0);
        // Strap window with an active comparator.
        strap_min = 1'b1;
        for (int i = 0; i < 150; i++) cyc($urandom_range(0, 3), 1, 0);
        chk("R7 forced code", int'(drv_code), 63);
        strap_min = 1'b0;
        for (int i = 0; i < 3; i++) cyc(1, 0, 0);
        // Random comparator and traffic mix.
        for (int i = 0; i < 3000; i++)
            cyc($urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        @(negedge clk);
        cmp_model();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule